// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates five interrupt requests for a small 8-bit processor core. One source cannot be masked. Three restart-style sources can be masked, and each has a hard-wired 16-bit vector address. The fifth is a general-purpose request line, and when it wins, the core takes its next instruction from an external device instead of jumping to a vector. The sources differ in how they are detected. The non-maskable source needs a rising edge followed by a level that is still high. Restart 7.5 latches a rising edge. Restarts 6.5 and 5.5 and the general-purpose line are level sensitive.

The chosen interrupt is presented as a registered grant on a valid/ready interface. `grant_valid` rises with a vector and an external-instruction flag. The core consumes the grant by driving `grant_ready` high for one cycle. Back-pressure rules:
- While `grant_valid` is high and `grant_ready` is low, the grant stays unchanged.
- A grant is never dropped or replaced before it is accepted, even if a higher-priority request arrives.
- A new grant can load at the earliest in the cycle after an accept.

Software controls a global enable through two strobes and writes a mask register through a small write port.

Top module: `intc_vec_ctrl`

## Requirements
- R1: After reset, `grant_valid` is 0, `gp_ack_n` is 1, the global enable is off and all three restart masks are set, so no maskable source is granted until software enables and unmasks it.
- R2: Fixed priority, highest first: non-maskable, restart 7.5, restart 6.5, restart 5.5, general-purpose.
- R3: Vectors are 0x0024 (non-maskable), 0x003C (7.5), 0x0034 (6.5) and 0x002C (5.5), each with `grant_ext`=0. A general-purpose grant carries `grant_ext`=1 and vector 0x0000.
- R4: The non-maskable source is granted regardless of the global enable. It needs a rising edge and a level still high at arbitration. A level held high after acceptance gives no second grant.
- R5: A rising edge on restart 7.5 is remembered while 7.5 is masked, and it is granted once 7.5 is unmasked. The remembered edge is cleared by acceptance, by reset, or by a mask write with `mask_clr75`=1.
- R6: Restart 6.5 and 5.5 are level sensitive. A source whose mask bit is 1 is never granted. The mask bits are: `mask_bits[0]` for 5.5, `mask_bits[1]` for 6.5, `mask_bits[2]` for 7.5.
- R7: `ei` sets the global enable and `di` clears it; `di` wins if both are high. Accepting any maskable or general-purpose grant clears the enable. Accepting the non-maskable grant leaves it unchanged.
- R8: While `grant_valid`=1 and `grant_ready`=0, `grant_valid`, `grant_vector` and `grant_ext` hold their values.
- R9: Accepting a general-purpose grant drives `gp_ack_n` low for exactly the one following cycle.
- R10: A request seen at one rising clock edge appears as `grant_valid` after the second rising edge, provided no grant is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request, active high |
| r75_req | input | 1 | Restart 7.5 request, rising-edge latched |
| r65_req | input | 1 | Restart 6.5 request, level |
| r55_req | input | 1 | Restart 5.5 request, level |
| gp_req | input | 1 | General-purpose request, level |
| mask_wr | input | 1 | Mask register write strobe |
| mask_bits | input | 3 | New masks: [0] 5.5, [1] 6.5, [2] 7.5; 1 = masked |
| mask_clr75 | input | 1 | With `mask_wr`, clears the remembered 7.5 edge |
| ei | input | 1 | Set global enable |
| di | input | 1 | Clear global enable |
| grant_valid | output | 1 | A grant is offered |
| grant_vector | output | 16 | Vector address of the grant |
| grant_ext | output | 1 | Grant asks for an externally supplied instruction |
| grant_ready | input | 1 | Core accepts the offered grant |
| gp_ack_n | output | 1 | Active-low acknowledge for the general-purpose request |

## Verification
Every request needs two rising edges before it shows as a grant: one to capture it and one to load the grant register. The bench drives stimulus on falling edges and checks `grant_valid` one nanosecond after the falling edge that follows the second rising edge. It also checks the same point one cycle earlier to confirm the grant has not yet appeared. The acknowledge is due in the cycle after the accepting edge and is sampled at the two falling edges that follow. Negative checks, such as a masked source, a disabled enable or a cleared edge, are made after a window of several cycles that is longer than the two-cycle latency.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_NMI  = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_GP   = 3'd5
  } src_e;

  localparam int unsigned VEC_W = 16;
  localparam int unsigned N_MASK = 3;
  localparam logic [VEC_W-1:0] VEC_NMI = 16'h0024;
  localparam logic [VEC_W-1:0] VEC_R75 = 16'h003C;
  localparam logic [VEC_W-1:0] VEC_R65 = 16'h0034;
  localparam logic [VEC_W-1:0] VEC_R55 = 16'h002C;
  localparam logic [VEC_W-1:0] VEC_GP  = 16'h0000;
endpackage

// File: rtl/intc_capture.sv
module intc_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_i,
  input  logic r75_i,
  input  logic r65_i,
  input  logic r55_i,
  input  logic gp_i,
  input  logic clr_nmi,
  input  logic clr_r75,
  output logic nmi_pend,
  output logic r75_pend,
  output logic r65_lvl,
  output logic r55_lvl,
  output logic gp_lvl
);
  logic nmi_q, r75_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      r75_q    <= 1'b0;
      nmi_pend <= 1'b0;
      r75_pend <= 1'b0;
      r65_lvl  <= 1'b0;
      r55_lvl  <= 1'b0;
      gp_lvl   <= 1'b0;
    end else begin
      nmi_q    <= nmi_i;
      r75_q    <= r75_i;
      // pending survives only while the level stays high
      nmi_pend <= clr_nmi ? 1'b0 : (nmi_i & (nmi_pend | ~nmi_q));
      // a fresh edge wins over a clear in the same cycle
      r75_pend <= (r75_pend & ~clr_r75) | (r75_i & ~r75_q);
      r65_lvl  <= r65_i;
      r55_lvl  <= r55_i;
      gp_lvl   <= gp_i;
    end
  end

  // R4: an accepted non-maskable request is gone next cycle
  p_nmi_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr_nmi |=> !nmi_pend);

  // R5: an edge on the 7.5 input is always remembered
  p_edge_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (r75_i && !r75_q) |=> r75_pend);
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import intc_pkg::*;
(
  input  logic              nmi_pend,
  input  logic              r75_pend,
  input  logic              r65_lvl,
  input  logic              r55_lvl,
  input  logic              gp_lvl,
  input  logic [N_MASK-1:0] mask,
  input  logic              ie,
  output src_e              sel,
  output logic [VEC_W-1:0]  vec,
  output logic              ext
);
  always_comb begin
    sel = SRC_NONE;
    if (nmi_pend)                      sel = SRC_NMI;
    else if (ie && r75_pend && !mask[2]) sel = SRC_R75;
    else if (ie && r65_lvl && !mask[1])  sel = SRC_R65;
    else if (ie && r55_lvl && !mask[0])  sel = SRC_R55;
    else if (ie && gp_lvl)               sel = SRC_GP;
  end

  always_comb begin
    ext = 1'b0;
    unique case (sel)
      SRC_NMI: vec = VEC_NMI;
      SRC_R75: vec = VEC_R75;
      SRC_R65: vec = VEC_R65;
      SRC_R55: vec = VEC_R55;
      SRC_GP:  begin vec = VEC_GP; ext = 1'b1; end
      default: vec = '0;
    endcase
  end
endmodule

// File: rtl/intc_vec_ctrl.sv
module intc_vec_ctrl
  import intc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_req,
  input  logic             r75_req,
  input  logic             r65_req,
  input  logic             r55_req,
  input  logic             gp_req,
  input  logic             mask_wr,
  input  logic [2:0]       mask_bits,
  input  logic             mask_clr75,
  input  logic             ei,
  input  logic             di,
  output logic             grant_valid,
  output logic [VEC_W-1:0] grant_vector,
  output logic             grant_ext,
  input  logic             grant_ready,
  output logic             gp_ack_n
);
  logic              nmi_pend, r75_pend, r65_lvl, r55_lvl, gp_lvl;
  logic [N_MASK-1:0] mask_q;
  logic              ie_q;
  src_e              sel, grant_src;
  logic [VEC_W-1:0]  sel_vec;
  logic              sel_ext;
  logic              accept;

  assign accept = grant_valid & grant_ready;

  intc_capture u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .nmi_i    (nmi_req),
    .r75_i    (r75_req),
    .r65_i    (r65_req),
    .r55_i    (r55_req),
    .gp_i     (gp_req),
    .clr_nmi  (accept && grant_src == SRC_NMI),
    .clr_r75  ((accept && grant_src == SRC_R75) || (mask_wr && mask_clr75)),
    .nmi_pend (nmi_pend),
    .r75_pend (r75_pend),
    .r65_lvl  (r65_lvl),
    .r55_lvl  (r55_lvl),
    .gp_lvl   (gp_lvl)
  );

  intc_arbiter u_arbiter (
    .nmi_pend (nmi_pend),
    .r75_pend (r75_pend),
    .r65_lvl  (r65_lvl),
    .r55_lvl  (r55_lvl),
    .gp_lvl   (gp_lvl),
    .mask     (mask_q),
    .ie       (ie_q),
    .sel      (sel),
    .vec      (sel_vec),
    .ext      (sel_ext)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '1;
      ie_q   <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_bits;
      if (di || (accept && grant_src != SRC_NMI)) ie_q <= 1'b0;
      else if (ei)                                ie_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid  <= 1'b0;
      grant_vector <= '0;
      grant_ext    <= 1'b0;
      grant_src    <= SRC_NONE;
      gp_ack_n     <= 1'b1;
    end else begin
      gp_ack_n <= ~(accept && grant_src == SRC_GP);
      if (accept) begin
        grant_valid <= 1'b0;
        grant_src   <= SRC_NONE;
      end else if (!grant_valid && sel != SRC_NONE) begin
        grant_valid  <= 1'b1;
        grant_vector <= sel_vec;
        grant_ext    <= sel_ext;
        grant_src    <= sel;
      end
    end
  end

  // R8: an offered grant is held until accepted
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && !grant_ready) |=> (grant_valid && $stable(grant_vector) && $stable(grant_ext)));

  // R9: acknowledge is a single-cycle pulse caused by a general-purpose accept
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !gp_ack_n |=> gp_ack_n);
  p_ack_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gp_ack_n) |-> $past(grant_valid && grant_ready && grant_ext));

  // R7: any maskable accept drops the global enable
  p_ie_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && grant_src != SRC_NMI) |=> !ie_q);

  // R6: a 6.5 grant only loads when unmasked and enabled
  p_mask65_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(grant_valid) && grant_vector == VEC_R65 && !grant_ext) |-> $past(!mask_q[1] && ie_q));

  // R3: the external flag only accompanies the zero vector
  p_ext_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && grant_ext) |-> grant_vector == VEC_GP);
endmodule

// File: tb/intc_vec_ctrl_bench.sv
`timescale 1ns/1ps
module intc_vec_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_req = 0, r75_req = 0, r65_req = 0, r55_req = 0, gp_req = 0;
  logic mask_wr = 0, mask_clr75 = 0, ei = 0, di = 0, grant_ready = 0;
  logic [2:0] mask_bits = 3'b111;
  logic grant_valid, grant_ext, gp_ack_n;
  logic [15:0] grant_vector;

  int checks = 0;
  int errors = 0;
  logic [16:0] expq[$];
  string tagq[$];

  always #10 clk = ~clk;

  intc_vec_ctrl u_intc_vec_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .r75_req(r75_req),
    .r65_req(r65_req), .r55_req(r55_req), .gp_req(gp_req),
    .mask_wr(mask_wr), .mask_bits(mask_bits), .mask_clr75(mask_clr75),
    .ei(ei), .di(di), .grant_valid(grant_valid), .grant_vector(grant_vector),
    .grant_ext(grant_ext), .grant_ready(grant_ready), .gp_ack_n(gp_ack_n)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: compare each accepted grant against the scoreboard
  always begin
    @(negedge clk);
    #1;
    if (rst_n && grant_valid && grant_ready) begin
      if (expq.size() == 0) check(0, "R2 unexpected grant", grant_vector, 0);
      else begin
        logic [16:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check({grant_ext, grant_vector} == e, t, {grant_ext, grant_vector}, e);
      end
    end
  end

  task automatic pulse_ei();
    ei = 1; tick(1); ei = 0;
  endtask

  task automatic write_mask(input logic [2:0] m, input logic clr);
    mask_bits = m; mask_clr75 = clr; mask_wr = 1; tick(1); mask_wr = 0; mask_clr75 = 0;
  endtask

  // driver: push expected item, wait for the grant, accept it
  task automatic serve(input logic [16:0] e, input string tag);
    int n = 0;
    expq.push_back(e);
    tagq.push_back(tag);
    while (!grant_valid && n < 20) begin tick(1); n++; end
    if (!grant_valid) check(0, {tag, " no grant"}, 0, 1);
    grant_ready = 1; tick(1); grant_ready = 0;
  endtask

  task automatic expect_idle(input int n, input string tag);
    tick(n); #1;
    check(grant_valid == 0, tag, grant_valid, 0);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    #1;
    check(grant_valid == 0, "R1 valid after reset", grant_valid, 0);
    check(gp_ack_n == 1, "R1 ack after reset", gp_ack_n, 1);

    // R1: reset leaves sources masked and enable off
    r65_req = 1;
    expect_idle(5, "R1 masked after reset");
    write_mask(3'b000, 0);
    expect_idle(5, "R1 enable off after reset");
    r65_req = 0; tick(2);

    // R4, R10: NMI with enable off, two-edge latency
    nmi_req = 1;
    tick(1); #1;
    check(grant_valid == 0, "R10 not after one edge", grant_valid, 0);
    tick(1); #1;
    check(grant_valid == 1, "R10 valid after two edges", grant_valid, 1);
    check(grant_vector == 16'h0024, "R4 NMI taken with enable off", grant_vector, 16'h0024);
    tick(3); #1;
    check(grant_valid == 1 && grant_vector == 16'h0024, "R8 hold while not ready", grant_vector, 16'h0024);
    serve({1'b0, 16'h0024}, "R3 NMI vector");
    expect_idle(5, "R4 no second NMI on held level");
    nmi_req = 0; tick(2);

    // R2: all at once
    pulse_ei();
    nmi_req = 1; r75_req = 1; r65_req = 1; r55_req = 1; gp_req = 1;
    tick(1); r75_req = 0;
    serve({1'b0, 16'h0024}, "R2 NMI first");
    serve({1'b0, 16'h003C}, "R2 r75 second");
    expect_idle(4, "R7 enable cleared by maskable accept");
    pulse_ei();
    serve({1'b0, 16'h0034}, "R2 r65 third");
    r65_req = 0;
    pulse_ei();
    serve({1'b0, 16'h002C}, "R2 r55 fourth");
    r55_req = 0;
    pulse_ei();
    serve({1'b1, 16'h0000}, "R3 general-purpose grant");
    #1;
    check(gp_ack_n == 0, "R9 ack low after accept", gp_ack_n, 0);
    tick(1); #1;
    check(gp_ack_n == 1, "R9 ack one cycle only", gp_ack_n, 1);
    gp_req = 0; nmi_req = 0; tick(2);

    // R6: masked level source ignored, then granted when unmasked
    write_mask(3'b010, 0);
    pulse_ei();
    r65_req = 1;
    expect_idle(5, "R6 masked r65 ignored");
    write_mask(3'b000, 0);
    serve({1'b0, 16'h0034}, "R6 r65 after unmask");
    r65_req = 0; tick(2);

    // R5: edge remembered while masked
    write_mask(3'b100, 0);
    pulse_ei();
    r75_req = 1; tick(1); r75_req = 0;
    expect_idle(5, "R5 masked r75 waits");
    write_mask(3'b000, 0);
    serve({1'b0, 16'h003C}, "R5 remembered edge granted");
    // R5: clear bit drops the remembered edge
    write_mask(3'b100, 0);
    pulse_ei();
    r75_req = 1; tick(1); r75_req = 0;
    tick(2);
    write_mask(3'b100, 1);
    write_mask(3'b000, 0);
    expect_idle(5, "R5 clear bit drops edge");

    // R7: di clears enable; di wins over ei
    pulse_ei();
    di = 1; ei = 1; tick(1); di = 0; ei = 0;
    r55_req = 1;
    expect_idle(5, "R7 di wins and blocks r55");
    r55_req = 0; tick(2);

    check(expq.size() == 0, "R2 scoreboard drained", expq.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule